// File: doc/BRIEF.md
# Video Control Register File with Interrupt Unit

This block is the register bank that sits between the CPU bus and the video engines. It accepts byte, halfword and 32-bit accesses on a small register window. Internally every access becomes one or two halfword operations. A bus sequencer walks through a short chain of states: `S_IDLE`, then `S_LO` for the halfword at the given address, then `S_HI` for the halfword at address+2 (32-bit accesses only), then `S_DONE`, where the acknowledge and read data are presented.

The named transitions are:
- `S_IDLE`→`S_LO` when a request is sampled.
- `S_LO`→`S_HI` for a 32-bit access.
- `S_LO`→`S_DONE` for a byte or halfword access.
- `S_HI`→`S_DONE`.
- `S_DONE`→`S_IDLE`.

The bank stores display control, three brightness levels and an idle-length value, a frame repeat count, two column-table pointers, drawing control, line-table entries, packed palettes and a background colour. It also reports engine status bits. An interrupt unit gathers event requests from the engines, filters them through an enable register and raises a single CPU interrupt line. Software can acknowledge pending causes by writing a clear register. A separate 5-bit line-compare field sits in the drawing control register.

Top module: `vreg_top`

Register map (byte offset, halfword-aligned):

| Offset | Register |
|---|---|
| 0x00 | pending (read only) |
| 0x02 | enable |
| 0x04 | clear |
| 0x06 | version |
| 0x08 | display status |
| 0x0A | display control |
| 0x0C, 0x0E, 0x10 | brightness 0..2 |
| 0x12 | idle length |
| 0x14 | frame count |
| 0x16 | column pointers |
| 0x18 | draw status |
| 0x1A | draw control |
| 0x1C..0x22 | line tables 0..3 |
| 0x24..0x32 | palettes 0..7 |
| 0x34 | background colour |

## Requirements
- R1: A write to the enable register (0x02) keeps only the bits set in 0xE01F. Reading 0x02 back returns exactly those kept bits.
- R2: An event request bit sets the matching pending bit (read at 0x00) and asserts `irq` one clock later, but only when the same enable bit is set. Disabled requests leave pending and `irq` unchanged.
- R3: A write to the clear register (0x04) removes the written bits from pending. `irq` falls only when pending becomes zero. The clear register reads as zero.
- R4: When an event request and a clear write land on the same clock edge, the newly requested bit remains pending and `irq` stays high.
- R5: A 32-bit access (size 2) performs the halfword at the given address first and the halfword at address+2 second. Read data returns as {high, low}. Each access produces a one-cycle `bus_ack`.
- R6: A byte write (size 0) at an odd address writes the full halfword with the data byte in bits 15:8 and zeros in 7:0. At an even address it writes the byte zero-extended.
- R7: A byte read at an even address returns bits 7:0 of the halfword in `bus_rdata[7:0]`. At an odd address it returns bits 15:8. All other `bus_rdata` bits are zero.
- R8: Each palette register keeps written bits 7:2 (three 2-bit entries at 7:6, 5:4, 3:2). Bits 1:0 and 15:8 read as zero.
- R9: The frame count register keeps 4 bits, each line-table register keeps 10 bits and the background colour keeps 2 bits. Reads and the matching outputs show only those bits.
- R10: The version register reads 2. Unmapped offsets, the display control register (0x0A) and the draw control register (0x1A) all read as zero.
- R11: Display status (0x08) reads these bits: lock at 10, sync enable at 9, refresh at 8, `frame_clk` at 7, `scan_ready` at 6, and `buf_busy[3:0]` at 5:2. Display-on is at bit 1. Lock, sync enable, refresh and display-on are written through 0x0A at bits 10, 9, 8 and 1. Draw control 0x1A sets `line_cmp` from bits 12:8 and `draw_on` from bit 1. Draw status 0x18 shows `draw_on` at bit 1.
- R12: The column pointer register (0x16) holds the right pointer in bits 15:8 and the left pointer in bits 7:0. Both pointers reset to 0xFA and drive `col_right` and `col_left`.
- R13: After reset, every register other than the version and column pointer registers reads zero, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Access request, sampled while idle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word |
| bus_addr | input | 7 | Byte offset in the register window |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | One-cycle access completion |
| bus_rdata | output | 32 | Read data, valid with `bus_ack` |
| event_req | input | 16 | Interrupt cause requests from the engines |
| frame_clk | input | 1 | Frame phase status bit |
| scan_ready | input | 1 | Scanner ready status bit |
| buf_busy | input | 4 | Buffer busy flags {right1, left1, right0, left0} |
| irq | output | 1 | CPU interrupt line |
| disp_ctl | output | 4 | {lock, sync enable, refresh, display on} |
| draw_on | output | 1 | Drawing enable |
| line_cmp | output | 5 | Drawing line-compare value |
| frame_cyc | output | 4 | Frame repeat count |
| col_left | output | 8 | Left column-table pointer |
| col_right | output | 8 | Right column-table pointer |
| back_color | output | 2 | Background colour |

## Verification
The assertions check four things on every cycle:
- `irq` is high exactly when pending is non-zero.
- Pending and enable hold no bits outside 0xE01F.
- An enabled request is pending one cycle later.
- Pending never gains bits without a request.

They also check that acknowledges are single pulses that follow an access state, and that stored configuration moves only on the edges that close `S_LO` or `S_HI`.

Field packing, palette and width truncation, byte-lane conversion, word splitting order and the same-edge set/clear priority are value questions. Only the bench's scenarios can show them. To do so, the bench sweeps every halfword offset, all palette data values, every status input combination and every interrupt bit.

// File: rtl/vreg_pkg.sv
package vreg_pkg;

    localparam int          HALF_W      = 16;
    localparam int          WORD_W      = 32;
    localparam logic [15:0] IRQ_EN_MASK = 16'hE01F;
    localparam logic [15:0] VERSION_ID  = 16'd2;
    localparam logic [7:0]  COL_RESET   = 8'hFA;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_LO   = 2'd1,
        S_HI   = 2'd2,
        S_DONE = 2'd3
    } seq_state_e;

    // halfword indices of the fixed registers
    localparam int HX_PEND  = 0;
    localparam int HX_MASK  = 1;
    localparam int HX_CLR   = 2;
    localparam int HX_VER   = 3;
    localparam int HX_DSTAT = 4;
    localparam int HX_DCTRL = 5;
    localparam int HX_LUM0  = 6;
    localparam int HX_FCYC  = 10;
    localparam int HX_COL   = 11;
    localparam int HX_XSTAT = 12;
    localparam int HX_XCTRL = 13;
    localparam int HX_SCAN0 = 14;

    // palette storage: entries 3..1 live in value bits 7:2
    function automatic logic [5:0] pal_pack(input logic [15:0] v);
        return v[7:2];
    endfunction

    function automatic logic [15:0] pal_unpack(input logic [5:0] q);
        return {8'h00, q, 2'b00};
    endfunction

endpackage

// File: rtl/vreg_bus_seq.sv
module vreg_bus_seq
    import vreg_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req,
    input  logic                we,
    input  logic [1:0]          size,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [WORD_W-1:0]   wdata,
    output logic                ack,
    output logic [WORD_W-1:0]   rdata,
    output logic                acc_en,
    output logic                acc_we,
    output logic [ADDR_W-2:0]   acc_hidx,
    output logic [HALF_W-1:0]   acc_wval,
    input  logic [HALF_W-1:0]   acc_rval,
    output seq_state_e          state_o
);

    localparam int HIDX_W = ADDR_W - 1;

    seq_state_e           state_q, state_d;
    logic                 we_q;
    acc_size_e            size_q;
    logic [ADDR_W-1:0]    addr_q;
    logic [WORD_W-1:0]    wdata_q;
    logic [HALF_W-1:0]    lo_q, hi_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (req) state_d = S_LO;
            S_LO:   state_d = (size_q == SZ_WORD) ? S_HI : S_DONE;
            S_HI:   state_d = S_DONE;
            S_DONE: state_d = S_IDLE;
        endcase
    end

    // request capture and read latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_q    <= 1'b0;
            size_q  <= SZ_HALF;
            addr_q  <= '0;
            wdata_q <= '0;
            lo_q    <= '0;
            hi_q    <= '0;
        end else begin
            if (state_q == S_IDLE && req) begin
                we_q    <= we;
                size_q  <= acc_size_e'(size);
                addr_q  <= addr;
                wdata_q <= wdata;
            end
            if (state_q == S_LO) lo_q <= acc_rval;
            if (state_q == S_HI) hi_q <= acc_rval;
        end
    end

    // outputs
    always_comb begin
        acc_en   = (state_q == S_LO) || (state_q == S_HI);
        acc_we   = we_q;
        acc_hidx = addr_q[ADDR_W-1:1];
        acc_wval = wdata_q[15:0];
        if (state_q == S_HI) begin
            acc_hidx = addr_q[ADDR_W-1:1] + HIDX_W'(1);
            acc_wval = wdata_q[31:16];
        end else if (size_q == SZ_BYTE) begin
            acc_wval = addr_q[0] ? {wdata_q[7:0], 8'h00} : {8'h00, wdata_q[7:0]};
        end
        ack   = (state_q == S_DONE);
        rdata = '0;
        if (state_q == S_DONE) begin
            unique case (size_q)
                SZ_WORD: rdata = {hi_q, lo_q};
                SZ_BYTE: rdata = {24'h0, addr_q[0] ? lo_q[15:8] : lo_q[7:0]};
                default: rdata = {16'h0, lo_q};
            endcase
        end
        state_o = state_q;
    end

endmodule

// File: rtl/vreg_irq.sv
module vreg_irq
    import vreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HALF_W-1:0] ev_req,
    input  logic              mask_we,
    input  logic              clr_we,
    input  logic [HALF_W-1:0] wval,
    output logic [HALF_W-1:0] mask_q,
    output logic [HALF_W-1:0] pend_q,
    output logic              irq
);

    logic [HALF_W-1:0] set_v, clr_v, pend_d;
    logic              irq_d;

    always_comb begin
        set_v  = ev_req & mask_q;
        clr_v  = clr_we ? wval : '0;
        pend_d = (pend_q & ~clr_v) | set_v;   // set wins over clear
        irq_d  = irq;
        if (set_v != '0)                          irq_d = 1'b1;
        else if (clr_we && pend_d == '0)          irq_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            pend_q <= '0;
            irq    <= 1'b0;
        end else begin
            if (mask_we) mask_q <= wval & IRQ_EN_MASK;
            pend_q <= pend_d;
            irq    <= irq_d;
        end
    end

endmodule

// File: rtl/vreg_regs.sv
module vreg_regs
    import vreg_pkg::*;
#(
    parameter int ADDR_W   = 7,
    parameter int NUM_LUM  = 4,
    parameter int NUM_SCAN = 4,
    parameter int SCAN_W   = 10,
    parameter int NUM_PAL  = 8,
    parameter int FCYC_W   = 4,
    parameter int BACK_W   = 2,
    parameter int CMP_W    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              acc_we,
    input  logic [ADDR_W-2:0] acc_hidx,
    input  logic [HALF_W-1:0] acc_wval,
    output logic [HALF_W-1:0] acc_rval,
    input  logic [HALF_W-1:0] irq_mask,
    input  logic [HALF_W-1:0] irq_pend,
    output logic              mask_we,
    output logic              clr_we,
    input  logic              frame_clk,
    input  logic              scan_ready,
    input  logic [3:0]        buf_busy,
    output logic [3:0]        disp_ctl,
    output logic              draw_on,
    output logic [CMP_W-1:0]  line_cmp,
    output logic [FCYC_W-1:0] frame_cyc,
    output logic [7:0]        col_left,
    output logic [7:0]        col_right,
    output logic [BACK_W-1:0] back_color
);

    localparam int HIDX_W   = ADDR_W - 1;
    localparam int HX_PAL0  = HX_SCAN0 + NUM_SCAN;
    localparam int HX_BACK  = HX_PAL0 + NUM_PAL;

    logic wr;
    assign wr      = acc_en && acc_we;
    assign mask_we = wr && (acc_hidx == HIDX_W'(HX_MASK));
    assign clr_we  = wr && (acc_hidx == HIDX_W'(HX_CLR));

    // display control {lock, sync, refresh, on}
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                    disp_ctl <= '0;
        else if (wr && acc_hidx == HIDX_W'(HX_DCTRL))  disp_ctl <= {acc_wval[10:8], acc_wval[1]};
    end

    // drawing control
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            draw_on  <= 1'b0;
            line_cmp <= '0;
        end else if (wr && acc_hidx == HIDX_W'(HX_XCTRL)) begin
            draw_on  <= acc_wval[1];
            line_cmp <= acc_wval[8 +: CMP_W];
        end
    end

    // frame count, column pointers, background colour
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frame_cyc  <= '0;
            col_left   <= COL_RESET;
            col_right  <= COL_RESET;
            back_color <= '0;
        end else if (wr) begin
            if (acc_hidx == HIDX_W'(HX_FCYC)) frame_cyc <= acc_wval[FCYC_W-1:0];
            if (acc_hidx == HIDX_W'(HX_COL)) begin
                col_right <= acc_wval[15:8];
                col_left  <= acc_wval[7:0];
            end
            if (acc_hidx == HIDX_W'(HX_BACK)) back_color <= acc_wval[BACK_W-1:0];
        end
    end

    // brightness levels and idle length
    logic [HALF_W-1:0] lum_rd [NUM_LUM];
    for (genvar g = 0; g < NUM_LUM; g++) begin : g_lum
        logic [HALF_W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                        q <= '0;
            else if (wr && acc_hidx == HIDX_W'(HX_LUM0 + g))   q <= acc_wval;
        end
        assign lum_rd[g] = q;
    end

    // line tables
    logic [HALF_W-1:0] scan_rd [NUM_SCAN];
    for (genvar g = 0; g < NUM_SCAN; g++) begin : g_scan
        logic [SCAN_W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                        q <= '0;
            else if (wr && acc_hidx == HIDX_W'(HX_SCAN0 + g))  q <= acc_wval[SCAN_W-1:0];
        end
        assign scan_rd[g] = HALF_W'(q);
    end

    // palettes
    logic [HALF_W-1:0] pal_rd [NUM_PAL];
    for (genvar g = 0; g < NUM_PAL; g++) begin : g_pal
        logic [5:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                        q <= '0;
            else if (wr && acc_hidx == HIDX_W'(HX_PAL0 + g))   q <= pal_pack(acc_wval);
        end
        assign pal_rd[g] = pal_unpack(q);
    end

    // read selection
    always_comb begin
        acc_rval = '0;
        if      (acc_hidx == HIDX_W'(HX_PEND))  acc_rval = irq_pend;
        else if (acc_hidx == HIDX_W'(HX_MASK))  acc_rval = irq_mask;
        else if (acc_hidx == HIDX_W'(HX_VER))   acc_rval = VERSION_ID;
        else if (acc_hidx == HIDX_W'(HX_DSTAT))
            acc_rval = {5'b0, disp_ctl[3:1], frame_clk, scan_ready, buf_busy, disp_ctl[0], 1'b0};
        else if (acc_hidx == HIDX_W'(HX_FCYC))  acc_rval = HALF_W'(frame_cyc);
        else if (acc_hidx == HIDX_W'(HX_COL))   acc_rval = {col_right, col_left};
        else if (acc_hidx == HIDX_W'(HX_XSTAT)) acc_rval = {14'b0, draw_on, 1'b0};
        else if (acc_hidx == HIDX_W'(HX_BACK))  acc_rval = HALF_W'(back_color);
        for (int i = 0; i < NUM_LUM; i++)
            if (acc_hidx == HIDX_W'(HX_LUM0 + i)) acc_rval = lum_rd[i];
        for (int i = 0; i < NUM_SCAN; i++)
            if (acc_hidx == HIDX_W'(HX_SCAN0 + i)) acc_rval = scan_rd[i];
        for (int i = 0; i < NUM_PAL; i++)
            if (acc_hidx == HIDX_W'(HX_PAL0 + i)) acc_rval = pal_rd[i];
    end

endmodule

// File: rtl/vreg_top.sv
module vreg_top
    import vreg_pkg::*;
#(
    parameter int ADDR_W   = 7,
    parameter int NUM_SCAN = 4,
    parameter int NUM_PAL  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [1:0]        bus_size,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic              bus_ack,
    output logic [31:0]       bus_rdata,
    input  logic [15:0]       event_req,
    input  logic              frame_clk,
    input  logic              scan_ready,
    input  logic [3:0]        buf_busy,
    output logic              irq,
    output logic [3:0]        disp_ctl,
    output logic              draw_on,
    output logic [4:0]        line_cmp,
    output logic [3:0]        frame_cyc,
    output logic [7:0]        col_left,
    output logic [7:0]        col_right,
    output logic [1:0]        back_color
);

    logic              acc_en, acc_we, mask_we, clr_we;
    logic [ADDR_W-2:0] acc_hidx;
    logic [15:0]       acc_wval, acc_rval, mask_w, pend_w;
    seq_state_e        seq_state;

    vreg_bus_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (bus_req),
        .we       (bus_we),
        .size     (bus_size),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .ack      (bus_ack),
        .rdata    (bus_rdata),
        .acc_en   (acc_en),
        .acc_we   (acc_we),
        .acc_hidx (acc_hidx),
        .acc_wval (acc_wval),
        .acc_rval (acc_rval),
        .state_o  (seq_state)
    );

    vreg_regs #(
        .ADDR_W   (ADDR_W),
        .NUM_LUM  (4),
        .NUM_SCAN (NUM_SCAN),
        .SCAN_W   (10),
        .NUM_PAL  (NUM_PAL),
        .FCYC_W   (4),
        .BACK_W   (2),
        .CMP_W    (5)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_en     (acc_en),
        .acc_we     (acc_we),
        .acc_hidx   (acc_hidx),
        .acc_wval   (acc_wval),
        .acc_rval   (acc_rval),
        .irq_mask   (mask_w),
        .irq_pend   (pend_w),
        .mask_we    (mask_we),
        .clr_we     (clr_we),
        .frame_clk  (frame_clk),
        .scan_ready (scan_ready),
        .buf_busy   (buf_busy),
        .disp_ctl   (disp_ctl),
        .draw_on    (draw_on),
        .line_cmp   (line_cmp),
        .frame_cyc  (frame_cyc),
        .col_left   (col_left),
        .col_right  (col_right),
        .back_color (back_color)
    );

    vreg_irq u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev_req  (event_req),
        .mask_we (mask_we),
        .clr_we  (clr_we),
        .wval    (acc_wval),
        .mask_q  (mask_w),
        .pend_q  (pend_w),
        .irq     (irq)
    );

endmodule

// File: rtl/vreg_chk.sv
module vreg_chk
    import vreg_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        bus_ack,
    input logic [15:0] event_req,
    input logic        irq,
    input logic [15:0] pend,
    input logic [15:0] mask,
    input logic [7:0]  col_left,
    input logic [7:0]  col_right,
    input logic [3:0]  frame_cyc,
    input seq_state_e  state
);

    a_r1_mask_legal: assert property (@(posedge clk) disable iff (!rst_n)
        ((mask | pend) & ~IRQ_EN_MASK) == 16'h0);

    a_r2_enabled_event_pends: assert property (@(posedge clk) disable iff (!rst_n)
        ((event_req & mask) != 16'h0) |=> (irq && ((pend & $past(event_req & mask)) == $past(event_req & mask))));

    a_r3_irq_tracks_pending: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (pend != 16'h0));

    a_r3_no_spontaneous_pend: assert property (@(posedge clk) disable iff (!rst_n)
        (event_req == 16'h0) |=> ((pend & ~$past(pend)) == 16'h0));

    a_r5_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);

    a_r5_ack_after_access: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> ($past(state) == S_LO || $past(state) == S_HI));

    a_r12_cfg_stable_outside_access: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE || state == S_DONE) |=>
            ($stable(col_left) && $stable(col_right) && $stable(frame_cyc)));

endmodule

bind vreg_top vreg_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_ack   (bus_ack),
    .event_req (event_req),
    .irq       (irq),
    .pend      (pend_w),
    .mask      (mask_w),
    .col_left  (col_left),
    .col_right (col_right),
    .frame_cyc (frame_cyc),
    .state     (seq_state)
);

// File: tb/tb_vreg_top.sv
`timescale 1ns/1ps
module tb_vreg_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [1:0]  bus_size = 2'd1;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ack;
    logic [31:0] bus_rdata;
    logic [15:0] event_req = '0;
    logic        frame_clk = 1'b0, scan_ready = 1'b0;
    logic [3:0]  buf_busy = '0;
    logic        irq, draw_on;
    logic [3:0]  disp_ctl, frame_cyc;
    logic [4:0]  line_cmp;
    logic [7:0]  col_left, col_right;
    logic [1:0]  back_color;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;

    always #5 clk = ~clk;

    vreg_top dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata), .event_req(event_req),
        .frame_clk(frame_clk), .scan_ready(scan_ready), .buf_busy(buf_busy),
        .irq(irq), .disp_ctl(disp_ctl), .draw_on(draw_on), .line_cmp(line_cmp),
        .frame_cyc(frame_cyc), .col_left(col_left), .col_right(col_right),
        .back_color(back_color)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            $display("FAIL R5 watchdog: actual=hang expected=completion");
            $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic we, input logic [1:0] sz, input logic [6:0] a,
                        input logic [31:0] wd, output logic [31:0] rd);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_size = sz; bus_addr = a; bus_wdata = wd;
        @(negedge clk);
        bus_req = 1'b0;
        while (!bus_ack) @(negedge clk);
        rd = bus_rdata;
    endtask

    task automatic wr16(input logic [6:0] a, input logic [15:0] v);
        logic [31:0] d;
        xfer(1'b1, 2'd1, a, {16'h0, v}, d);
    endtask

    task automatic rd16(input logic [6:0] a, output logic [31:0] v);
        xfer(1'b0, 2'd1, a, 32'h0, v);
    endtask

    task automatic pulse_event(input logic [15:0] v);
        @(negedge clk); event_req = v;
        @(negedge clk); event_req = '0;
    endtask

    function automatic logic [15:0] reset_val(input int h);
        case (h)
            3:       return 16'h0002;
            11:      return 16'hFAFA;
            default: return 16'h0000;
        endcase
    endfunction

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R13 / R10 / R12: reset contents across every halfword offset
        chk("R13 irq after reset", {31'b0, irq}, 32'h0);
        chk("R12 col_left reset", {24'h0, col_left}, 32'hFA);
        chk("R12 col_right reset", {24'h0, col_right}, 32'hFA);
        for (int h = 0; h < 64; h++) begin
            rd16(7'(h * 2), r);
            chk($sformatf("R13 reset read h%0d", h), r, {16'h0, reset_val(h)});
        end

        // R1: enable mask
        wr16(7'h02, 16'hFFFF);
        rd16(7'h02, r);
        chk("R1 enable mask", r, 32'h0000_E01F);

        // R2 / R3: each cause bit through set and clear
        for (int b = 0; b < 16; b++) begin
            logic [15:0] e;
            e = (16'h1 << b) & 16'hE01F;
            pulse_event(16'h1 << b);
            chk($sformatf("R2 irq bit%0d", b), {31'b0, irq}, {31'b0, e != 0});
            rd16(7'h00, r);
            chk($sformatf("R2 pending bit%0d", b), r, {16'h0, e});
            wr16(7'h04, 16'hFFFF);
            chk($sformatf("R3 irq cleared bit%0d", b), {31'b0, irq}, 32'h0);
        end

        // R3: partial clear keeps line up
        pulse_event(16'h0011);
        wr16(7'h04, 16'h0001);
        rd16(7'h00, r);
        chk("R3 partial clear pending", r, 32'h0010);
        chk("R3 irq held", {31'b0, irq}, 32'h1);
        rd16(7'h04, r);
        chk("R3 clear reads zero", r, 32'h0);
        wr16(7'h04, 16'h0010);
        chk("R3 irq drops when empty", {31'b0, irq}, 32'h0);

        // R4: set and clear on the same edge
        pulse_event(16'h0011);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_size = 2'd1; bus_addr = 7'h04; bus_wdata = 32'h0011;
        @(negedge clk);
        bus_req = 1'b0; event_req = 16'h0010;
        @(negedge clk);
        event_req = '0;
        while (!bus_ack) @(negedge clk);
        rd16(7'h00, r);
        chk("R4 set wins pending", r, 32'h0010);
        chk("R4 set wins irq", {31'b0, irq}, 32'h1);
        wr16(7'h04, 16'hFFFF);

        // R2: disabled causes ignored
        wr16(7'h02, 16'h0000);
        pulse_event(16'hFFFF);
        chk("R2 disabled irq", {31'b0, irq}, 32'h0);
        rd16(7'h00, r);
        chk("R2 disabled pending", r, 32'h0);

        // R5: word write/read split
        xfer(1'b1, 2'd2, 7'h0C, 32'h1234_5678, r);
        rd16(7'h0C, r);
        chk("R5 low half at addr", r, 32'h5678);
        rd16(7'h0E, r);
        chk("R5 high half at addr+2", r, 32'h1234);
        xfer(1'b0, 2'd2, 7'h0C, 32'h0, r);
        chk("R5 word read", r, 32'h1234_5678);
        xfer(1'b0, 2'd2, 7'h04, 32'h0, r);
        chk("R5 word read clear+version", r, 32'h0002_0000);

        // R6 / R12: byte writes
        xfer(1'b1, 2'd0, 7'h17, 32'h12, r);
        rd16(7'h16, r);
        chk("R6 odd byte write", r, 32'h1200);
        chk("R12 col_right out", {24'h0, col_right}, 32'h12);
        chk("R12 col_left out", {24'h0, col_left}, 32'h00);
        xfer(1'b1, 2'd0, 7'h16, 32'hFF34, r);
        rd16(7'h16, r);
        chk("R6 even byte write", r, 32'h0034);

        // R7: byte reads
        wr16(7'h16, 16'hABCD);
        xfer(1'b0, 2'd0, 7'h16, 32'h0, r);
        chk("R7 even byte read", r, 32'hCD);
        xfer(1'b0, 2'd0, 7'h17, 32'h0, r);
        chk("R7 odd byte read", r, 32'hAB);

        // R8: palettes, all data values
        for (int p = 0; p < 8; p++) begin
            for (int v = 0; v < 256; v++) begin
                wr16(7'(8'h24 + p * 2), 16'hFF00 | 16'(v));
                rd16(7'(8'h24 + p * 2), r);
                chk($sformatf("R8 palette %0d value %0d", p, v), r, 32'(v & 8'hFC));
            end
        end

        // R9: widths
        wr16(7'h14, 16'hFFFF);
        rd16(7'h14, r);
        chk("R9 frame count read", r, 32'h000F);
        chk("R9 frame count out", {28'h0, frame_cyc}, 32'hF);
        for (int s = 0; s < 4; s++) begin
            wr16(7'(8'h1C + s * 2), 16'hFFFF - 16'(s));
            rd16(7'(8'h1C + s * 2), r);
            chk($sformatf("R9 line table %0d", s), r, 32'(16'h03FF - 16'(s)));
        end
        wr16(7'h34, 16'hFFFE);
        rd16(7'h34, r);
        chk("R9 background read", r, 32'h0002);
        chk("R9 background out", {30'h0, back_color}, 32'h2);

        // R10: write-only and unmapped
        wr16(7'h40, 16'hFFFF);
        rd16(7'h40, r);
        chk("R10 unmapped reads zero", r, 32'h0);
        rd16(7'h06, r);
        chk("R10 version", r, 32'h2);

        // R11: display control and status sweep
        wr16(7'h0A, 16'h0702);
        chk("R11 disp_ctl out", {28'h0, disp_ctl}, 32'hF);
        rd16(7'h0A, r);
        chk("R10 display control reads zero", r, 32'h0);
        for (int v = 0; v < 64; v++) begin
            @(negedge clk);
            frame_clk = v[5]; scan_ready = v[4]; buf_busy = v[3:0];
            rd16(7'h08, r);
            chk($sformatf("R11 status %0d", v), r, 32'h0702 | 32'(v << 2));
        end
        wr16(7'h0A, 16'h0400);
        rd16(7'h08, r);
        chk("R11 lock only", r, 32'h0400 | 32'(63 << 2));
        wr16(7'h1A, 16'h1F02);
        chk("R11 draw_on", {31'b0, draw_on}, 32'h1);
        chk("R11 line_cmp", {27'h0, line_cmp}, 32'h1F);
        rd16(7'h18, r);
        chk("R11 draw status", r, 32'h0002);
        rd16(7'h1A, r);
        chk("R10 draw control reads zero", r, 32'h0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule